// File: doc/BRIEF.md
# Incrementally Reconfigurable Port Crossbar

This block joins a set of N ports through a symmetric crossbar. Every unordered pair of distinct ports owns one configuration bit. When that bit is set, the two ports are joined, so any port can reach any other port. Setting several bits that share one port joins that port to a whole set of others, which gives multicast and broadcast. Software-facing logic drives a command interface that makes or breaks one pair per cycle, sets the direction of one port per cycle, or wipes every pair bit at once. A read-back path reports any pair bit one cycle after it is asked for.

The pair bits are deliberately left unchanged by reset, so a live routing survives a reset of the block. After power-up, clear-all must be issued to remove leftover joins. Each port is either an input or an output. An output port drives the OR of all input ports joined to it. The ports form four equal output-enable groups, and the external pad logic treats a low drive enable as high impedance. Pin inputs are sampled on a shared input clock (`clk`, which also runs the command logic). Resolved outputs are registered on a separate shared output clock (`oclk`).

Top module: `pair_xbar`

## Requirements
- R1: A pair is named (a, b) in either order and maps to one stored bit, so make(a,b) followed by a read-back of (b,a) returns 1.
- R2: A make (op code 0) or break (op code 1) changes only the addressed pair bit. The change is visible from the next `clk` cycle, and every other pair bit keeps its value.
- R3: An output port joined to several input ports drives the OR of their sampled values (multicast). Several output ports may share one input port (broadcast).
- R4: Reset does not change any pair bit. Reset returns every port direction to input, clears the error flag and the read-back output, and clears all outputs and valid flags.
- R5: `clear_all` zeroes every pair bit in one cycle. When a command arrives in the same cycle as `clear_all`, `clear_all` wins and the command leaves no pair bit set.
- R6: A command with a equal to b, with either index N or more, or with op code 3 is ignored. It changes no pair bit and no direction, and `cmd_err` is high for exactly the following cycle.
- R7: Op code 2 writes port a's direction from `cmd_dir` (1 = output, 0 = input) and leaves the other ports unchanged.
- R8: Output-direction neighbours do not contribute to a port's output. An output port with no input-direction port joined to it drives 0 with `out_vld` low. When at least one input port is joined, `out_vld` is high. Input-direction ports always show 0 with `out_vld` low.
- R9: Port p belongs to group p/(N/4). `pin_oe[p]` is high only when port p is an output and `grp_oe` for its group is high, and `pin_out[p]` is 0 whenever `pin_oe[p]` is low.
- R10: `pin_in` is sampled on a `clk` rising edge, and the resolved value reaches `pin_out` at the following `oclk` rising edge.
- R11: The read-back returns, one `clk` cycle after the query, the pair bit as it stood before that same edge's update. A query with equal or out-of-range indices returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command, configuration and input-sampling clock |
| oclk | input | 1 | Output register clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_all | input | 1 | Zero every pair bit this cycle |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 make, 1 break, 2 set direction, 3 reserved |
| cmd_a | input | IDXW | First port index |
| cmd_b | input | IDXW | Second port index (pair commands) |
| cmd_dir | input | 1 | Direction for op 2: 1 output, 0 input |
| cmd_err | output | 1 | One-cycle flag for an ignored command |
| rd_a | input | IDXW | Read-back query, first index |
| rd_b | input | IDXW | Read-back query, second index |
| rd_bit | output | 1 | Queried pair bit, one cycle later |
| pin_in | input | NPORTS | Port input values |
| grp_oe | input | 4 | Output enable per port group |
| pin_out | output | NPORTS | Resolved port output values |
| pin_oe | output | NPORTS | Per-port drive enable (low = high impedance) |
| out_vld | output | NPORTS | Output port has an input-direction neighbour |

## Verification
On every cycle, the embedded properties check the following. Clear-all empties the pair store. A make or break sets or clears its own bit, and no update touches more than one bit. An ignored command leaves the store stable. Drive enables appear only on output-direction ports, and an output without a valid source stays at 0. Only the directed scenarios can show the rest: the symmetry of (a,b) against (b,a), the OR resolution across multicast and broadcast fans, the exclusion of output-direction neighbours, the group mapping of the enables, the survival of pair bits across reset, and the exact cycle on which read-back and pin outputs change.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [1:0] {
        OP_MAKE  = 2'd0,
        OP_BREAK = 2'd1,
        OP_DIR   = 2'd2,
        OP_RSVD  = 2'd3
    } xbar_op_e;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } port_dir_e;

    // Number of unordered pairs of distinct ports.
    function automatic int unsigned pair_count(int unsigned n);
        return (n * (n - 1)) / 2;
    endfunction

    // Flat position of pair (lo, hi), lo < hi, in row-major triangle order.
    function automatic int unsigned pair_index(int unsigned n, int unsigned lo, int unsigned hi);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

endpackage

// File: rtl/xbar_cmd_dec.sv
module xbar_cmd_dec
    import xbar_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int IDXW   = 4,
    parameter int PIDXW  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  xbar_op_e         cmd_op,
    input  logic [IDXW-1:0]  cmd_a,
    input  logic [IDXW-1:0]  cmd_b,
    input  logic             cmd_dir,
    output logic             pair_we,
    output logic             pair_set,
    output logic [PIDXW-1:0] pair_sel,
    output logic             dir_we,
    output logic [IDXW-1:0]  dir_sel,
    output port_dir_e        dir_val,
    output logic             err
);

    localparam int NPAIRS = int'(pair_count(NPORTS));

    logic            a_ok, b_ok, pair_ok, bad;
    logic [IDXW-1:0] lo, hi;
    logic            err_q;

    always_comb begin
        a_ok    = int'(cmd_a) < NPORTS;
        b_ok    = int'(cmd_b) < NPORTS;
        pair_ok = a_ok && b_ok && (cmd_a != cmd_b);
        lo      = (cmd_a < cmd_b) ? cmd_a : cmd_b;
        hi      = (cmd_a < cmd_b) ? cmd_b : cmd_a;
        pair_sel = PIDXW'(pair_index(NPORTS, int'(lo), int'(hi)));
        pair_set = (cmd_op == OP_MAKE);
        dir_sel  = cmd_a;
        dir_val  = port_dir_e'(cmd_dir);
        pair_we  = 1'b0;
        dir_we   = 1'b0;
        bad      = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_MAKE, OP_BREAK: begin
                    pair_we = pair_ok;
                    bad     = !pair_ok;
                end
                OP_DIR: begin
                    dir_we = a_ok;
                    bad    = !a_ok;
                end
                default: bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= bad;
    end

    assign err = err_q;

    // R1
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        pair_we |-> (int'(pair_sel) < NPAIRS));

    // R7
    one_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pair_we, dir_we}));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_we || dir_we || !cmd_valid) |=> !err_q);

endmodule

// File: rtl/xbar_pair_store.sv
module xbar_pair_store
    import xbar_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int IDXW   = 4,
    parameter int PIDXW  = 5,
    parameter int NPAIRS = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              pair_we,
    input  logic              pair_set,
    input  logic [PIDXW-1:0]  pair_sel,
    input  logic [IDXW-1:0]   rd_a,
    input  logic [IDXW-1:0]   rd_b,
    output logic              rd_bit,
    output logic [NPAIRS-1:0] pairs
);

    logic [NPAIRS-1:0] pairs_q;
    logic              rd_q;
    logic              rd_ok;
    logic [IDXW-1:0]   rd_lo, rd_hi;
    logic [PIDXW-1:0]  rd_sel;

    // Pair bits carry no reset: routing survives a block reset.
    always_ff @(posedge clk) begin
        if (clear_all)    pairs_q <= '0;
        else if (pair_we) pairs_q[pair_sel] <= pair_set;
    end

    always_comb begin
        rd_ok  = (int'(rd_a) < NPORTS) && (int'(rd_b) < NPORTS) && (rd_a != rd_b);
        rd_lo  = (rd_a < rd_b) ? rd_a : rd_b;
        rd_hi  = (rd_a < rd_b) ? rd_b : rd_a;
        rd_sel = PIDXW'(pair_index(NPORTS, int'(rd_lo), int'(rd_hi)));
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= 1'b0;
        else if (rd_ok) rd_q <= pairs_q[rd_sel];
        else            rd_q <= 1'b0;
    end

    assign rd_bit = rd_q;
    assign pairs  = pairs_q;

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (pairs_q == '0));

    // R2
    make_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_we && pair_set && !clear_all) |=> pairs_q[$past(pair_sel)]);

    // R2
    break_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_we && !pair_set && !clear_all) |=> !pairs_q[$past(pair_sel)]);

    // R2
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_all |=> ($countones(pairs_q ^ $past(pairs_q)) <= 1));

    // R11
    rd_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |=> !rd_q);

endmodule

// File: rtl/xbar_port_cfg.sv
module xbar_port_cfg
    import xbar_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int IDXW   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_we,
    input  logic [IDXW-1:0]   dir_sel,
    input  port_dir_e         dir_val,
    output logic [NPORTS-1:0] dir_out
);

    logic [NPORTS-1:0] dir_q;

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)                                 dir_q[gp] <= DIR_IN;
            else if (dir_we && int'(dir_sel) == gp)  dir_q[gp] <= dir_val;
        end
    end

    assign dir_out = dir_q;

    // R7
    dir_single_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(dir_q ^ $past(dir_q)) <= 1));

    // R7
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dir_we |=> $stable(dir_q));

endmodule

// File: rtl/xbar_resolve.sv
module xbar_resolve
    import xbar_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int PIDXW  = 5,
    parameter int NPAIRS = 28,
    parameter int NGRP   = 4
) (
    input  logic              clk,
    input  logic              oclk,
    input  logic              rst,
    input  logic [NPAIRS-1:0] pairs,
    input  logic [NPORTS-1:0] dir_out,
    input  logic [NPORTS-1:0] pin_in,
    input  logic [NGRP-1:0]   grp_oe,
    output logic [NPORTS-1:0] pin_out,
    output logic [NPORTS-1:0] pin_oe,
    output logic [NPORTS-1:0] out_vld
);

    localparam int GRP = NPORTS / NGRP;

    logic [NPORTS-1:0] in_q;
    logic [NPORTS-1:0] drive_d, hit_d;
    logic [NPORTS-1:0] out_q, vld_q;

    // Input sampling on the shared input clock.
    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= pin_in;
    end

    // OR of every input-direction port joined to each output port.
    always_comb begin
        drive_d = '0;
        hit_d   = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int q = 0; q < NPORTS; q++) begin
                if (q != p) begin
                    if (pairs[PIDXW'(pair_index(NPORTS, (p < q) ? p : q, (p < q) ? q : p))]
                        && (dir_out[q] == DIR_IN)) begin
                        hit_d[p]   = 1'b1;
                        drive_d[p] = drive_d[p] | in_q[q];
                    end
                end
            end
            if (dir_out[p] == DIR_IN) begin
                hit_d[p]   = 1'b0;
                drive_d[p] = 1'b0;
            end
        end
    end

    // Output register on the shared output clock.
    always_ff @(posedge oclk) begin
        if (rst) begin
            out_q <= '0;
            vld_q <= '0;
        end else begin
            out_q <= drive_d;
            vld_q <= hit_d;
        end
    end

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_pad
        assign pin_oe[gp]  = dir_out[gp] & grp_oe[gp / GRP];
        assign pin_out[gp] = out_q[gp] & pin_oe[gp];
    end

    assign out_vld = vld_q;

    // R8
    no_src_zero_chk: assert property (@(posedge oclk) disable iff (rst)
        ((out_q & ~vld_q) == '0));

    // R9
    oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~dir_out) == '0));

    // R9
    hiz_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));

endmodule

// File: rtl/pair_xbar.sv
module pair_xbar
    import xbar_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int IDXW   = $clog2(NPORTS) + 1,
    parameter int NGRP   = 4
) (
    input  logic              clk,
    input  logic              oclk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDXW-1:0]   cmd_a,
    input  logic [IDXW-1:0]   cmd_b,
    input  logic              cmd_dir,
    output logic              cmd_err,
    input  logic [IDXW-1:0]   rd_a,
    input  logic [IDXW-1:0]   rd_b,
    output logic              rd_bit,
    input  logic [NPORTS-1:0] pin_in,
    input  logic [NGRP-1:0]   grp_oe,
    output logic [NPORTS-1:0] pin_out,
    output logic [NPORTS-1:0] pin_oe,
    output logic [NPORTS-1:0] out_vld
);

    localparam int NPAIRS = int'(pair_count(NPORTS));
    localparam int PIDXW  = (NPAIRS > 1) ? $clog2(NPAIRS) : 1;

    logic              pair_we, pair_set, dir_we;
    logic [PIDXW-1:0]  pair_sel;
    logic [IDXW-1:0]   dir_sel;
    port_dir_e         dir_val;
    logic [NPAIRS-1:0] pairs;
    logic [NPORTS-1:0] dir_out;

    xbar_cmd_dec #(.NPORTS(NPORTS), .IDXW(IDXW), .PIDXW(PIDXW)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_op   (xbar_op_e'(cmd_op)),
        .cmd_a    (cmd_a),
        .cmd_b    (cmd_b),
        .cmd_dir  (cmd_dir),
        .pair_we  (pair_we),
        .pair_set (pair_set),
        .pair_sel (pair_sel),
        .dir_we   (dir_we),
        .dir_sel  (dir_sel),
        .dir_val  (dir_val),
        .err      (cmd_err)
    );

    xbar_pair_store #(.NPORTS(NPORTS), .IDXW(IDXW), .PIDXW(PIDXW), .NPAIRS(NPAIRS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clear_all(clear_all),
        .pair_we  (pair_we),
        .pair_set (pair_set),
        .pair_sel (pair_sel),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .rd_bit   (rd_bit),
        .pairs    (pairs)
    );

    xbar_port_cfg #(.NPORTS(NPORTS), .IDXW(IDXW)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .dir_we (dir_we),
        .dir_sel(dir_sel),
        .dir_val(dir_val),
        .dir_out(dir_out)
    );

    xbar_resolve #(.NPORTS(NPORTS), .PIDXW(PIDXW), .NPAIRS(NPAIRS), .NGRP(NGRP)) u_res (
        .clk    (clk),
        .oclk   (oclk),
        .rst    (rst),
        .pairs  (pairs),
        .dir_out(dir_out),
        .pin_in (pin_in),
        .grp_oe (grp_oe),
        .pin_out(pin_out),
        .pin_oe (pin_oe),
        .out_vld(out_vld)
    );

    // R6
    invalid_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_err && !$past(clear_all)) |-> $stable(pairs));

    // R6
    invalid_dir_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $stable(dir_out));

endmodule

// File: tb/tb_pair_xbar.sv
module tb_pair_xbar;

    localparam int N  = 8;
    localparam int IW = 4;

    logic          clk = 1'b0, oclk = 1'b0, rst = 1'b1;
    logic          clear_all = 1'b0, cmd_valid = 1'b0, cmd_dir = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [IW-1:0] cmd_a = '0, cmd_b = '0, rd_a = '0, rd_b = '0;
    logic          cmd_err, rd_bit;
    logic [N-1:0]  pin_in = '0, pin_out, pin_oe, out_vld;
    logic [3:0]    grp_oe = 4'hF;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    initial begin
        #15 oclk = 1'b1;
        forever #10 oclk = ~oclk;
    end

    pair_xbar #(.NPORTS(N)) dut (
        .clk(clk), .oclk(oclk), .rst(rst), .clear_all(clear_all),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .cmd_dir(cmd_dir), .cmd_err(cmd_err), .rd_a(rd_a), .rd_b(rd_b),
        .rd_bit(rd_bit), .pin_in(pin_in), .grp_oe(grp_oe), .pin_out(pin_out),
        .pin_oe(pin_oe), .out_vld(out_vld)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Tasks start and end on a falling clk edge.
    task automatic cmd(input int op, input int a, input int b, input bit d);
        cmd_op = 2'(op); cmd_a = IW'(a); cmd_b = IW'(b); cmd_dir = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic query(input int a, input int b, output bit v);
        rd_a = IW'(a); rd_b = IW'(b);
        @(negedge clk);
        v = rd_bit;
    endtask

    task automatic wipe();
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R4 err in reset", int'(cmd_err), 0);
        chk("R4 oe in reset", int'(pin_oe), 0);
        chk("R4 vld in reset", int'(out_vld), 0);
        chk("R4 rd in reset", int'(rd_bit), 0);
        rst = 1'b0;
        @(negedge clk);
        wipe();
    endtask

    task automatic t_symmetric();
        bit v;
        cmd(0, 5, 2, 0);
        query(2, 5, v); chk("R1 swapped readback", int'(v), 1);
        query(5, 2, v); chk("R1 same bit", int'(v), 1);
        cmd(1, 2, 5, 0);
        query(5, 2, v); chk("R1 break swapped", int'(v), 0);
    endtask

    task automatic t_isolation();
        bit v;
        cmd(0, 1, 2, 0);
        cmd(0, 6, 5, 0);
        cmd(1, 1, 2, 0);
        query(1, 2, v); chk("R2 broken pair", int'(v), 0);
        query(5, 6, v); chk("R2 neighbour kept", int'(v), 1);
        cmd(1, 0, 7, 0);
        query(6, 5, v); chk("R2 break of unset pair", int'(v), 1);
        wipe();
    endtask

    task automatic t_multicast();
        cmd(2, 0, 0, 1);
        cmd(2, 3, 0, 1);
        chk("R7 dir written", int'(pin_oe), 32'h09);
        cmd(0, 0, 1, 0);
        cmd(0, 2, 0, 0);
        cmd(0, 0, 3, 0);
        pin_in = 8'b0000_1000;
        @(negedge clk);
        chk("R8 output neighbour ignored", int'(pin_out[0]), 0);
        chk("R8 vld with inputs joined", int'(out_vld[0]), 1);
        chk("R8 no input source vld", int'(out_vld[3]), 0);
        pin_in = 8'b0000_0100;
        @(negedge clk);
        chk("R3 or of sources", int'(pin_out[0]), 1);
        pin_in = 8'b0000_0010;
        @(negedge clk);
        chk("R3 other source", int'(pin_out[0]), 1);
        chk("R8 input port shows 0", int'(out_vld[1]), 0);
        // broadcast: port 3 also listens to port 2
        cmd(0, 3, 2, 0);
        pin_in = 8'b0000_0100;
        @(negedge clk);
        chk("R3 broadcast both outputs", int'(pin_out & 8'h09), 9);
        pin_in = '0;
        cmd(2, 0, 0, 0);
        cmd(2, 3, 0, 0);
        wipe();
    endtask

    task automatic t_timing();
        cmd(2, 4, 0, 1);
        cmd(0, 4, 7, 0);
        @(negedge clk);
        pin_in[7] = 1'b1;
        #5;
        chk("R10 before clk edge", int'(pin_out[4]), 0);
        @(posedge clk); #2;
        chk("R10 before oclk edge", int'(pin_out[4]), 0);
        @(posedge oclk); #2;
        chk("R10 after oclk edge", int'(pin_out[4]), 1);
        @(negedge clk);
    endtask

    task automatic t_groups();
        // port 4 output, joined to 7 which is high
        grp_oe = 4'b1011;
        #1;
        chk("R9 group off oe", int'(pin_oe[4]), 0);
        chk("R9 group off out", int'(pin_out[4]), 0);
        grp_oe = 4'b0100;
        #1;
        chk("R9 group on", int'(pin_oe[4]) + int'(pin_out[4]), 2);
        grp_oe = 4'hF;
        pin_in = '0;
        @(negedge clk);
    endtask

    task automatic t_reset_keeps();
        bit v;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 dir back to input", int'(pin_oe[4]), 0);
        query(7, 4, v); chk("R4 pair kept", int'(v), 1);
        wipe();
    endtask

    task automatic t_clear();
        bit v;
        cmd(0, 1, 6, 0);
        cmd(0, 0, 3, 0);
        clear_all = 1'b1;
        cmd(0, 4, 7, 0);
        clear_all = 1'b0;
        query(4, 7, v); chk("R5 clear beats make", int'(v), 0);
        query(1, 6, v); chk("R5 old pair cleared", int'(v), 0);
        query(0, 3, v); chk("R5 second pair cleared", int'(v), 0);
    endtask

    task automatic t_invalid();
        bit v;
        cmd(0, 3, 3, 0);
        chk("R6 equal indices err", int'(cmd_err), 1);
        @(negedge clk);
        chk("R6 err one cycle", int'(cmd_err), 0);
        cmd(0, 2, 9, 0);
        chk("R6 range err", int'(cmd_err), 1);
        query(2, 1, v); chk("R6 no alias write", int'(v), 0);
        cmd(3, 0, 1, 0);
        chk("R6 reserved op err", int'(cmd_err), 1);
        query(0, 1, v); chk("R6 reserved no effect", int'(v), 0);
        cmd(2, 12, 0, 1);
        chk("R6 dir range err", int'(cmd_err), 1);
        chk("R6 no dir change", int'(pin_oe), 0);
    endtask

    task automatic t_readback();
        bit v;
        rd_a = 4'd2; rd_b = 4'd4;
        cmd(0, 2, 4, 0);
        chk("R11 old value on same edge", int'(rd_bit), 0);
        @(negedge clk);
        chk("R11 new value next", int'(rd_bit), 1);
        query(4, 4, v); chk("R11 equal query zero", int'(v), 0);
        query(15, 2, v); chk("R11 range query zero", int'(v), 0);
    endtask

    initial begin
        t_reset();
        t_symmetric();
        t_isolation();
        t_multicast();
        t_timing();
        t_groups();
        t_reset_keeps();
        t_clear();
        t_invalid();
        t_readback();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule